// File: doc/BRIEF.md
# Translation Buffer with Hardware Table Walk

This block translates virtual addresses to physical addresses through a small fully associative buffer of recent translations. When a lookup misses, the block reads the page table entry from memory itself and installs it in the buffer. It then repeats the lookup. Each access states its kind: instruction fetch, data read or data write. The block checks that kind against the page's permissions before it returns an address. A refused access, or an entry that is not valid, comes back as a fault code instead of an address.

The buffer keeps a modified flag for every entry. A write to a page sets the flag. When a modified entry is pushed out to make room, the block first writes the page table entry back to memory with the modified flag set. A flush input empties the buffer in one cycle and writes nothing back.

The page table has one level. It is an array of 32-bit entries that starts at the base address on `pt_base`. The entry for a virtual page sits at `pt_base + 4 * vpn`. In an entry, bit 0 is valid, bit 1 read, bit 2 write, bit 3 execute and bit 4 modified. The upper `VA_W - PAGE_BITS` bits hold the physical page number.

Top module: `tlb_walker`

## Requirements
- R1: A successful response carries the physical address formed from the physical page number in the upper bits and the request's page offset (low `PAGE_BITS` bits), which passes through unchanged.
- R2: A request whose page is held in the buffer completes with no memory request at all. Its response becomes valid one cycle after the request is accepted.
- R3: A miss issues exactly one memory read at `pt_base + 4 * vpn`. The block installs the returned entry, repeats the lookup, and then answers from the buffer.
- R4: If the fetched entry has bit 0 clear, the response carries fault code 1 (page fault) and a zero address. Nothing is installed, so the next access to that page walks again.
- R5: Access kind is encoded on `req_kind`: 0 is fetch, 1 is read, 2 is write, and 3 is treated as read. A fetch needs bit 3, a read needs bit 1 and a write needs bit 2. A refused access gets fault code 2 (protection fault) and a zero address.
- R6: A permitted write sets the entry's modified flag. When a modified entry is evicted, the block first writes memory at that page's entry address with the entry value and bits 0 and 4 set. Evicting a clean entry writes nothing.
- R7: To choose a victim, the block takes the lowest-numbered empty slot if one exists. Otherwise it takes a round-robin pointer, which starts at slot 0 after reset and advances each time it is used. With `ENTRIES` = 8, eight distinct pages fit without any eviction.
- R8: Only one request is in flight at a time. `req_ready` is high only while the block is idle, and it stays low for the whole of a walk.
- R9: A one-cycle pulse on `flush` empties every slot and causes no memory write. Every page accessed afterwards walks again.
- R10: Once raised, the response (`rsp_valid`, `rsp_paddr` and `rsp_fault`) holds steady until `rsp_ready` is seen. The memory request (`mem_req_valid`, `mem_req_addr` and `mem_req_write`) likewise holds steady until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all buffer slots |
| pt_base | input | VA_W | Page table base byte address, held stable while in use |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | VA_W | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | VA_W | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a write-back, 0 for an entry read |
| mem_req_addr | output | VA_W | Byte address of the page table entry |
| mem_req_wdata | output | VA_W | Entry value for a write-back |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_data | input | VA_W | Page table entry read |

## Verification
The bench walks one page table through misses and hits, and counts memory reads and writes per access. A design that walked on a hit, or that installed an invalid entry, would show the wrong read count. Each access kind is tried against pages that lack exactly the permission it needs. A design that swapped the read and execute checks would hand out an address where a protection fault is due.

The eviction test fills every slot after reset and dirties the first page. It then forces two evictions. This catches a replacement pointer that skips a slot, a missing or misaddressed write-back, and a write-back of a clean entry. A flush of a dirty page must cost a fresh walk and produce no write. A stalled requester must see an unchanged response.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_ALT   = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_PAGE = 2'd1,
      FLT_PROT = 2'd2
   } flt_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOOK, ST_RD, ST_WAIT, ST_WB, ST_RESP
   } st_e;

   // bit positions inside a page table entry
   localparam int PTE_V = 0;
   localparam int PTE_R = 1;
   localparam int PTE_W = 2;
   localparam int PTE_X = 3;
   localparam int PTE_D = 4;

   typedef struct packed {
      logic d;
      logic x;
      logic w;
      logic r;
   } perm_t;
endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam
   import tlbw_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic [PPN_W-1:0] hit_ppn,
   output perm_t            hit_perm,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic [VPN_W-1:0] ins_vpn,
   input  logic [PPN_W-1:0] ins_ppn,
   input  perm_t            ins_perm,
   input  logic             dirty_en,
   input  logic [IDX_W-1:0] dirty_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [VPN_W-1:0] rd_vpn,
   output logic [PPN_W-1:0] rd_ppn,
   output perm_t            rd_perm,
   output logic [ENTRIES-1:0] vld_vec
);
   logic [ENTRIES-1:0] vld_q;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   perm_t              perm_q [ENTRIES];
   logic [ENTRIES-1:0] match;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_match
      assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (match[i]) hit_idx = IDX_W'(i);
   end

   assign hit      = |match;
   assign hit_ppn  = ppn_q[hit_idx];
   assign hit_perm = perm_q[hit_idx];
   assign rd_vpn   = vpn_q[rd_idx];
   assign rd_ppn   = ppn_q[rd_idx];
   assign rd_perm  = perm_q[rd_idx];
   assign vld_vec  = vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          vld_q <= '0;
      else if (flush)      vld_q <= '0;
      else if (ins_en)     vld_q[ins_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (ins_en) begin
         vpn_q[ins_idx]  <= ins_vpn;
         ppn_q[ins_idx]  <= ins_ppn;
         perm_q[ins_idx] <= ins_perm;
      end else if (dirty_en) begin
         perm_q[dirty_idx].d <= 1'b1;
      end
   end
endmodule

// File: rtl/tlbw_victim.sv
module tlbw_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] vld_vec,
   input  logic               take,
   output logic [IDX_W-1:0]   victim_idx
);
   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_nxt;
   logic             found;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlbw_victim needs at least two entries");
   end

   if ((1 << IDX_W) == ENTRIES) begin : g_wrap_pow2
      assign rr_nxt = rr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign rr_nxt = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
   end

   always_comb begin
      victim_idx = rr_q;
      found      = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!found && !vld_vec[i]) begin
            victim_idx = IDX_W'(i);
            found      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 rr_q <= '0;
      else if (take && &vld_vec)  rr_q <= rr_nxt;
   end
endmodule

// File: rtl/tlbw_perm.sv
module tlbw_perm
   import tlbw_pkg::*;
(
   input  acc_e  kind,
   input  perm_t perm,
   output logic  allow
);
   always_comb begin
      unique case (kind)
         ACC_FETCH: allow = perm.x;
         ACC_STORE: allow = perm.w;
         default:   allow = perm.r;
      endcase
   end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
   import tlbw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 8,
   parameter int PTE_SHIFT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic [VA_W-1:0] pt_base,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [1:0]      req_kind,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic [VA_W-1:0] rsp_paddr,
   output logic [1:0]      rsp_fault,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic            mem_req_write,
   output logic [VA_W-1:0] mem_req_addr,
   output logic [VA_W-1:0] mem_req_wdata,
   input  logic            mem_rsp_valid,
   input  logic [VA_W-1:0] mem_rsp_data
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int IDX_W = $clog2(ENTRIES);

   if (PAGE_BITS <= PTE_D) begin : g_bad_page
      $error("PAGE_BITS must leave room for the entry flag bits");
   end
   if (VPN_W < 1) begin : g_bad_width
      $error("VA_W must exceed PAGE_BITS");
   end

   st_e              st_q;
   logic [VA_W-1:0]  va_q;
   acc_e             kind_q;
   logic [VA_W-1:0]  pte_q;
   logic [IDX_W-1:0] vic_q;
   logic [VA_W-1:0]  paddr_q;
   flt_e             fault_q;
   logic [VA_W-1:0]  wb_addr_q;
   logic [VA_W-1:0]  wb_data_q;

   logic             hit;
   logic [IDX_W-1:0] hit_idx;
   logic [VPN_W-1:0] hit_ppn;
   perm_t            hit_perm;
   logic             allow;
   logic             ins_en;
   logic [IDX_W-1:0] ins_idx;
   logic [VA_W-1:0]  ins_pte;
   perm_t            ins_perm;
   logic             dirty_en;
   logic [IDX_W-1:0] victim_idx;
   logic [VPN_W-1:0] rd_vpn;
   logic [VPN_W-1:0] rd_ppn;
   perm_t            rd_perm;
   logic [ENTRIES-1:0] vld_vec;
   logic [VPN_W-1:0] va_vpn;
   logic [VA_W-1:0]  walk_addr;
   logic             in_look;
   logic             in_wait;

   assign va_vpn    = va_q[VA_W-1:PAGE_BITS];
   assign walk_addr = pt_base + (VA_W'(va_vpn) << PTE_SHIFT);
   assign in_look   = (st_q == ST_LOOK);
   assign in_wait   = (st_q == ST_WAIT);

   assign ins_pte  = (st_q == ST_WB) ? pte_q : mem_rsp_data;
   assign ins_idx  = (st_q == ST_WB) ? vic_q : victim_idx;
   assign ins_perm = '{d: ins_pte[PTE_D], x: ins_pte[PTE_X],
                       w: ins_pte[PTE_W], r: ins_pte[PTE_R]};
   assign ins_en   = (in_wait && mem_rsp_valid && mem_rsp_data[PTE_V] &&
                      !(vld_vec[victim_idx] && rd_perm.d)) ||
                     (st_q == ST_WB && mem_req_ready);
   assign dirty_en = in_look && hit && allow && (kind_q == ACC_STORE);

   tlbw_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) i_cam (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_vpn(va_vpn), .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
      .hit_perm(hit_perm),
      .ins_en(ins_en), .ins_idx(ins_idx), .ins_vpn(va_vpn),
      .ins_ppn(ins_pte[VA_W-1:PAGE_BITS]), .ins_perm(ins_perm),
      .dirty_en(dirty_en), .dirty_idx(hit_idx),
      .rd_idx(victim_idx), .rd_vpn(rd_vpn), .rd_ppn(rd_ppn), .rd_perm(rd_perm),
      .vld_vec(vld_vec)
   );

   tlbw_victim #(.ENTRIES(ENTRIES)) i_victim (
      .clk(clk), .rst_n(rst_n), .vld_vec(vld_vec), .take(ins_en),
      .victim_idx(victim_idx)
   );

   tlbw_perm i_perm (.kind(kind_q), .perm(hit_perm), .allow(allow));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         kind_q    <= ACC_LOAD;
         pte_q     <= '0;
         vic_q     <= '0;
         paddr_q   <= '0;
         fault_q   <= FLT_NONE;
         wb_addr_q <= '0;
         wb_data_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q   <= req_vaddr;
               kind_q <= acc_e'(req_kind);
               st_q   <= ST_LOOK;
            end
            ST_LOOK: if (hit) begin
               fault_q <= allow ? FLT_NONE : FLT_PROT;
               paddr_q <= allow ? {hit_ppn, va_q[PAGE_BITS-1:0]} : '0;
               st_q    <= ST_RESP;
            end else begin
               st_q <= ST_RD;
            end
            ST_RD: if (mem_req_ready) st_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               pte_q <= mem_rsp_data;
               vic_q <= victim_idx;
               if (!mem_rsp_data[PTE_V]) begin
                  fault_q <= FLT_PAGE;
                  paddr_q <= '0;
                  st_q    <= ST_RESP;
               end else if (vld_vec[victim_idx] && rd_perm.d) begin
                  wb_addr_q <= pt_base + (VA_W'(rd_vpn) << PTE_SHIFT);
                  wb_data_q <= {rd_ppn, {(PAGE_BITS-PTE_D-1){1'b0}}, 1'b1,
                                rd_perm.x, rd_perm.w, rd_perm.r, 1'b1};
                  st_q      <= ST_WB;
               end else begin
                  st_q <= ST_LOOK;
               end
            end
            ST_WB: if (mem_req_ready) st_q <= ST_LOOK;
            ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign rsp_valid     = (st_q == ST_RESP);
   assign rsp_paddr     = paddr_q;
   assign rsp_fault     = fault_q;
   assign mem_req_valid = (st_q == ST_RD) || (st_q == ST_WB);
   assign mem_req_write = (st_q == ST_WB);
   assign mem_req_addr  = (st_q == ST_WB) ? wb_addr_q : walk_addr;
   assign mem_req_wdata = wb_data_q;
endmodule

// File: rtl/tlbw_chk.sv
module tlbw_chk #(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic            rsp_valid,
   input logic            rsp_ready,
   input logic [VA_W-1:0] rsp_paddr,
   input logic [1:0]      rsp_fault,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic            mem_req_write,
   input logic [VA_W-1:0] mem_req_addr,
   input logic [VA_W-1:0] mem_req_wdata
);
   logic [PAGE_BITS-1:0] off_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                      off_q <= '0;
      else if (req_valid && req_ready) off_q <= req_vaddr[PAGE_BITS-1:0];
   end

   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault == 2'd0 |-> rsp_paddr[PAGE_BITS-1:0] == off_q); // R1

   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0); // R5

   AST_WB_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_wdata[4] && mem_req_wdata[0]); // R6

   AST_NO_ACCEPT_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready); // R8

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R10

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                          && $stable(mem_req_write)); // R10
endmodule

bind tlb_walker tlbw_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) i_tlbw_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
   .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_tlb_walker.sv
module test_tlb_walker;
   localparam logic [31:0] BASE = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [31:0] pt_base = BASE;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = 2'd1;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int          n_chk = 0;
   int          n_fail = 0;
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   int          pend = 0;
   logic [31:0] rd_addr = '0;
   logic [31:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] pt [64];

   always #10 clk = ~clk;

   tlb_walker i_tlb_walker (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] pte_of(input int vpn);
      case (vpn)
         1: return 32'h0A00_1007;   // read, write
         2: return 32'h0A00_2000;   // not valid
         3: return 32'h0A00_3009;   // execute only
         4: return 32'h0A00_4003;   // read only
         5: return 32'h0A00_5005;   // write only
         default: return ((32'h0000_B000 + 32'(vpn)) << 12) | 32'h7;
      endcase
   endfunction

   function automatic int slot(input logic [31:0] a);
      return int'((a - BASE) >> 2) & 63;
   endfunction

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (!rst_n) pend <= 0;
      else if (mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            wr_cnt <= wr_cnt + 1;
            wr_addr <= mem_req_addr;
            wr_data <= mem_req_wdata;
            pt[slot(mem_req_addr)] <= mem_req_wdata;
         end else begin
            rd_cnt <= rd_cnt + 1;
            rd_addr <= mem_req_addr;
            pend <= 3;
         end
      end else if (pend == 1) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data <= pt[slot(rd_addr)];
         pend <= 0;
      end else if (pend > 1) pend <= pend - 1;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic access(input logic [31:0] va, input logic [1:0] kind,
                         output logic [31:0] pa, output logic [1:0] flt,
                         output int reads, output int writes, output bit leak);
      int r0;
      int w0;
      int n;
      r0 = rd_cnt;
      w0 = wr_cnt;
      @(negedge clk);
      req_vaddr = va; req_kind = kind; req_valid = 1'b1;
      n = 0;
      while (!req_ready && n < 1000) begin @(negedge clk); n++; end
      @(negedge clk);
      req_valid = 1'b0;
      leak = 1'b0;
      n = 0;
      while (!rsp_valid && n < 1000) begin
         if (req_ready) leak = 1'b1;
         @(negedge clk); n++;
      end
      pa = rsp_paddr;
      flt = rsp_fault;
      @(negedge clk);
      reads = rd_cnt - r0;
      writes = wr_cnt - w0;
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R8 ready after reset", 32'(req_ready), 32'd1);
      chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R8 idle outputs after reset",
          {30'd0, rsp_valid, mem_req_valid}, 32'd0);
   endtask

   task automatic t_miss_hit();
      logic [31:0] pa; logic [1:0] f; int r; int w; bit lk;
      access(32'h0000_1ABC, 2'd1, pa, f, r, w, lk);
      chk(pa == 32'h0A00_1ABC && f == 2'd0, "R1 miss translation", pa, 32'h0A00_1ABC);
      chk(r == 1 && rd_addr == BASE + 32'd4, "R3 one walk read at base+4*vpn", rd_addr, BASE + 32'd4);
      chk(!lk, "R8 ready low during walk", 32'(lk), 32'd0);
      access(32'h0000_1123, 2'd1, pa, f, r, w, lk);
      chk(pa == 32'h0A00_1123 && f == 2'd0, "R1 hit translation", pa, 32'h0A00_1123);
      chk(r == 0, "R2 hit makes no memory read", 32'(r), 32'd0);
   endtask

   task automatic t_page_fault();
      logic [31:0] pa; logic [1:0] f; int r; int w; bit lk;
      access(32'h0000_2010, 2'd1, pa, f, r, w, lk);
      chk(f == 2'd1 && pa == 32'd0, "R4 page fault code", {30'd0, f}, 32'd1);
      access(32'h0000_2010, 2'd1, pa, f, r, w, lk);
      chk(f == 2'd1 && r == 1, "R4 invalid entry not installed", 32'(r), 32'd1);
   endtask

   task automatic t_protect();
      logic [31:0] pa; logic [1:0] f; int r; int w; bit lk;
      access(32'h0000_1000, 2'd0, pa, f, r, w, lk);
      chk(f == 2'd2 && pa == 32'd0, "R5 fetch from non-exec page", {30'd0, f}, 32'd2);
      access(32'h0000_3004, 2'd0, pa, f, r, w, lk);
      chk(f == 2'd0 && pa == 32'h0A00_3004, "R5 fetch from exec page", pa, 32'h0A00_3004);
      access(32'h0000_3004, 2'd1, pa, f, r, w, lk);
      chk(f == 2'd2, "R5 read from exec-only page", {30'd0, f}, 32'd2);
      access(32'h0000_4008, 2'd2, pa, f, r, w, lk);
      chk(f == 2'd2, "R5 write to read-only page", {30'd0, f}, 32'd2);
      access(32'h0000_4008, 2'd3, pa, f, r, w, lk);
      chk(f == 2'd0 && pa == 32'h0A00_4008, "R5 kind 3 acts as read", pa, 32'h0A00_4008);
      access(32'h0000_5000, 2'd2, pa, f, r, w, lk);
      chk(f == 2'd0 && pa == 32'h0A00_5000, "R5 write to write-only page", pa, 32'h0A00_5000);
      access(32'h0000_5000, 2'd1, pa, f, r, w, lk);
      chk(f == 2'd2, "R5 read from write-only page", {30'd0, f}, 32'd2);
   endtask

   task automatic t_flush();
      logic [31:0] pa; logic [1:0] f; int r; int w; bit lk;
      int w0;
      access(32'h0000_1000, 2'd2, pa, f, r, w, lk);
      w0 = wr_cnt;
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      access(32'h0000_1040, 2'd1, pa, f, r, w, lk);
      chk(r == 1 && pa == 32'h0A00_1040, "R9 flushed page walks again", 32'(r), 32'd1);
      chk(wr_cnt == w0, "R9 flush writes nothing back", 32'(wr_cnt - w0), 32'd0);
   endtask

   task automatic t_evict();
      logic [31:0] pa; logic [1:0] f; int r; int w; bit lk;
      int tot;
      do_reset();
      for (int v = 10; v < 18; v++) access(32'(v) << 12, 2'd1, pa, f, r, w, lk);
      access(32'h0000_A010, 2'd2, pa, f, r, w, lk);
      chk(r == 0 && f == 2'd0, "R6 write hit on page 10", 32'(r), 32'd0);
      tot = 0;
      for (int v = 10; v < 18; v++) begin
         access(32'(v) << 12, 2'd1, pa, f, r, w, lk);
         tot += r;
      end
      chk(tot == 0, "R7 eight pages fill empty slots", 32'(tot), 32'd0);
      access(32'h0001_2000, 2'd1, pa, f, r, w, lk);
      chk(r == 1 && w == 1, "R6 dirty eviction writes back", 32'(w), 32'd1);
      chk(wr_addr == BASE + 32'd40, "R6 write-back address", wr_addr, BASE + 32'd40);
      chk(wr_data == (pte_of(10) | 32'h10), "R6 write-back value", wr_data, pte_of(10) | 32'h10);
      access(32'h0000_B000, 2'd1, pa, f, r, w, lk);
      chk(r == 0, "R7 slot 1 kept after first eviction", 32'(r), 32'd0);
      access(32'h0000_A000, 2'd1, pa, f, r, w, lk);
      chk(r == 1 && w == 0, "R6 clean eviction writes nothing", 32'(w), 32'd0);
      access(32'h0000_B000, 2'd1, pa, f, r, w, lk);
      chk(r == 1, "R7 round robin took slot 1 next", 32'(r), 32'd1);
   endtask

   task automatic t_hold();
      logic [31:0] pa0;
      int n;
      rsp_ready = 1'b0;
      @(negedge clk);
      req_vaddr = 32'h0000_B444; req_kind = 2'd1; req_valid = 1'b1;
      n = 0;
      while (!req_ready && n < 1000) begin @(negedge clk); n++; end
      @(negedge clk); req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 1000) begin @(negedge clk); n++; end
      pa0 = rsp_paddr;
      repeat (3) @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa0 && pa0 == 32'h0B00_B444,
          "R10 response held while stalled", rsp_paddr, 32'h0B00_B444);
      rsp_ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) pt[i] = pte_of(i);
      do_reset();
      t_reset();
      t_miss_hit();
      t_page_fault();
      t_protect();
      t_flush();
      t_evict();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule